// File: doc/BRIEF.md
# Handshaked Serial Byte Shifter

This block moves single bytes between a host and a power-management microcontroller over a serial link. The peer supplies the shift clock. A pair of active-low lines frames every byte: the block drives a request line and watches an acknowledge line that the peer drives. A local controller starts a transfer by pulsing a send command with a byte, or a receive command. The block then shifts eight bits on the peer's clock and releases the request line. It reports completion only once the peer has released acknowledge.

The shift clock, the serial data input and the acknowledge line are synchronized into the system clock domain. Bits move most significant first on each rising edge of the synchronized shift clock. The block has three outcomes:
- A normal completion pulse. For a receive, this pulse comes with the captured byte.
- A no-response error, raised when acknowledge stays low longer than a parameterized number of system cycles after the request is released.
- A warning pulse, raised when acknowledge is already high at the moment the eighth bit lands. The byte still completes in this case.

Top module: `hs_byte_shifter`

## Requirements
- R1: After a synchronous active-high reset, `req_n` is 1, `busy`, `done`, `rx_valid`, `timeout_err` and `ack_warn` are 0, and `rx_byte` is 0.
- R2: A `cmd_send` pulse while idle loads `tx_byte`, raises `busy` and drives `req_n` low in the same cycle. Before each of the eight rising `sclk_in` edges, `sdata_out` shows the byte's bits from bit 7 down to bit 0.
- R3: A `cmd_recv` pulse while idle clears the shift register and drives `req_n` low. `sdata_in` is taken on each rising `sclk_in` edge, first bit into bit 7. When the transfer finishes, `rx_byte` holds the byte and `rx_valid` pulses together with `done`.
- R4: After the eighth rising `sclk_in` edge, `req_n` returns high. `done` does not pulse while `ack_n` stays low. It pulses once `ack_n` is seen high, and `busy` falls with it.
- R5: A send transfer leaves `rx_byte` unchanged and never pulses `rx_valid`.
- R6: If `ack_n` stays low after `req_n` is released, `timeout_err` pulses exactly `TIMEOUT_CYC` cycles after `req_n` rises. No `done` pulse occurs and the block returns to idle.
- R7: If `ack_n` is high when the eighth bit completes, `ack_warn` pulses once, and the byte still finishes with `done`.
- R8: `cmd_send` and `cmd_recv` are ignored while `busy` is high. They neither change the byte being shifted nor cause an extra `done`.
- R9: If `cmd_send` and `cmd_recv` arrive in the same idle cycle, the send wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_send | input | 1 | Start a send of `tx_byte` (one-cycle pulse) |
| cmd_recv | input | 1 | Start a receive (one-cycle pulse) |
| tx_byte | input | W | Byte to send |
| sclk_in | input | 1 | Shift clock from the peer (asynchronous) |
| sdata_in | input | 1 | Serial data from the peer |
| sdata_out | output | 1 | Serial data to the peer, most significant bit first |
| req_n | output | 1 | Active-low transfer request |
| ack_n | input | 1 | Active-low acknowledge from the peer |
| busy | output | 1 | A byte is in progress |
| done | output | 1 | One-cycle pulse when a byte completes normally |
| rx_valid | output | 1 | One-cycle pulse with `done` after a receive |
| rx_byte | output | W | Last received byte |
| timeout_err | output | 1 | One-cycle pulse: acknowledge never returned high |
| ack_warn | output | 1 | One-cycle pulse: acknowledge was already high at shift completion |

## Verification
The bench builds the block with `W` = 8 and two synchronizer stages. It sets `TIMEOUT_CYC` to 40 instead of the production figure of tens of millions of cycles. This makes the no-response path reachable within a short run and lets the bench count the exact cycle distance from the request release to the error pulse. The long default stays valid because the limit only sets the width and terminal count of a counter.

// File: rtl/hsb_pkg.sv
package hsb_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SHIFT = 2'd1,
    ST_WAIT  = 2'd2
  } hsb_state_e;
endpackage

// File: rtl/hsb_sync.sv
module hsb_sync #(
  parameter int          N       = 3,
  parameter int          STAGES  = 2,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] d,
  output logic [N-1:0] q
);
  logic [N-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/hsb_shifter.sv
module hsb_shifter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load_tx,
  input  logic         clear_rx,
  input  logic [W-1:0] tx_byte,
  input  logic         dir_out,
  input  logic         step,
  input  logic         sin,
  output logic [W-1:0] shreg,
  output logic         word_done
);
  localparam int CW = $clog2(W);
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg     <= '0;
      cnt       <= '0;
      word_done <= 1'b0;
    end else begin
      word_done <= 1'b0;
      if (load_tx) begin
        shreg <= tx_byte;
        cnt   <= '0;
      end else if (clear_rx) begin
        shreg <= '0;
        cnt   <= '0;
      end else if (step) begin
        shreg <= {shreg[W-2:0], dir_out ? 1'b0 : sin};
        if (cnt == LAST) begin
          cnt       <= '0;
          word_done <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/hsb_timer.sv
module hsb_timer #(
  parameter int LIMIT = 1000
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic expired
);
  localparam int TW = $clog2(LIMIT + 1);
  localparam logic [TW-1:0] TERM = TW'(LIMIT - 1);

  logic [TW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !run) cnt <= '0;
    else if (cnt != TERM) cnt <= cnt + 1'b1;
  end

  assign expired = run && (cnt == TERM);
endmodule

// File: rtl/hs_byte_shifter.sv
module hs_byte_shifter
  import hsb_pkg::*;
#(
  parameter int W           = 8,
  parameter int SYNC_STAGES = 2,
  parameter int TIMEOUT_CYC = 32_000_000
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         cmd_send,
  input  logic         cmd_recv,
  input  logic [W-1:0] tx_byte,
  input  logic         sclk_in,
  input  logic         sdata_in,
  output logic         sdata_out,
  output logic         req_n,
  input  logic         ack_n,
  output logic         busy,
  output logic         done,
  output logic         rx_valid,
  output logic [W-1:0] rx_byte,
  output logic         timeout_err,
  output logic         ack_warn
);
  hsb_state_e   state;
  logic         dir_out;
  logic [2:0]   raw_in, sync_q;
  logic         sclk_s, sd_s, ack_s, sclk_prev, sclk_rise;
  logic         load_tx, clear_rx, step, word_done, expired;
  logic [W-1:0] shreg;

  assign raw_in = {sclk_in, sdata_in, ack_n};

  hsb_sync #(.N(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b001)) u_sync (
    .clk(clk), .rst(rst), .d(raw_in), .q(sync_q)
  );

  assign sclk_s = sync_q[2];
  assign sd_s   = sync_q[1];
  assign ack_s  = sync_q[0];

  always_ff @(posedge clk) begin
    if (rst) sclk_prev <= 1'b0;
    else     sclk_prev <= sclk_s;
  end

  assign sclk_rise = sclk_s & ~sclk_prev;
  assign load_tx   = (state == ST_IDLE) && cmd_send;
  assign clear_rx  = (state == ST_IDLE) && !cmd_send && cmd_recv;
  assign step      = (state == ST_SHIFT) && sclk_rise && !word_done;

  hsb_shifter #(.W(W)) u_shift (
    .clk(clk), .rst(rst), .load_tx(load_tx), .clear_rx(clear_rx),
    .tx_byte(tx_byte), .dir_out(dir_out), .step(step), .sin(sd_s),
    .shreg(shreg), .word_done(word_done)
  );

  hsb_timer #(.LIMIT(TIMEOUT_CYC)) u_timer (
    .clk(clk), .rst(rst), .run(state == ST_WAIT), .expired(expired)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      dir_out     <= 1'b0;
      req_n       <= 1'b1;
      done        <= 1'b0;
      rx_valid    <= 1'b0;
      timeout_err <= 1'b0;
      ack_warn    <= 1'b0;
      rx_byte     <= '0;
    end else begin
      done        <= 1'b0;
      rx_valid    <= 1'b0;
      timeout_err <= 1'b0;
      ack_warn    <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (cmd_send || cmd_recv) begin
            dir_out <= cmd_send;
            req_n   <= 1'b0;
            state   <= ST_SHIFT;
          end
        end
        ST_SHIFT: begin
          if (word_done) begin
            req_n    <= 1'b1;
            ack_warn <= ack_s;
            if (!dir_out) rx_byte <= shreg;
            state    <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (ack_s) begin
            done     <= 1'b1;
            rx_valid <= !dir_out;
            state    <= ST_IDLE;
          end else if (expired) begin
            timeout_err <= 1'b1;
            state       <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy      = (state != ST_IDLE);
  assign sdata_out = dir_out ? shreg[W-1] : 1'b1;
endmodule

// File: rtl/hs_byte_shifter_chk.sv
module hs_byte_shifter_chk (
  input logic clk,
  input logic rst,
  input logic req_n,
  input logic busy,
  input logic done,
  input logic rx_valid,
  input logic timeout_err,
  input logic ack_warn
);
  p_idle_req_released_r1: assert property (@(posedge clk) disable iff (rst)
    !busy |-> req_n);

  p_accept_drives_req_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> !req_n);

  p_rx_valid_with_done_r3: assert property (@(posedge clk) disable iff (rst)
    rx_valid |-> done);

  p_done_after_release_r4: assert property (@(posedge clk) disable iff (rst)
    done |-> (req_n && !busy));

  p_timeout_no_done_r6: assert property (@(posedge clk) disable iff (rst)
    timeout_err |-> (!done && !busy));

  p_warn_req_released_r7: assert property (@(posedge clk) disable iff (rst)
    ack_warn |-> (req_n && busy));

  p_single_done_r8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
endmodule

bind hs_byte_shifter hs_byte_shifter_chk u_chk (
  .clk(clk), .rst(rst), .req_n(req_n), .busy(busy), .done(done),
  .rx_valid(rx_valid), .timeout_err(timeout_err), .ack_warn(ack_warn)
);

// File: tb/hs_byte_shifter_bench.sv
module hs_byte_shifter_bench;
  localparam int W  = 8;
  localparam int TO = 40;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         cmd_send = 1'b0, cmd_recv = 1'b0;
  logic [W-1:0] tx_byte = '0;
  logic         sclk_in = 1'b0, sdata_in = 1'b0, ack_n = 1'b1;
  logic         sdata_out, req_n, busy, done, rx_valid, timeout_err, ack_warn;
  logic [W-1:0] rx_byte;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  hs_byte_shifter #(.W(W), .SYNC_STAGES(2), .TIMEOUT_CYC(TO)) u_hs_byte_shifter (
    .clk(clk), .rst(rst), .cmd_send(cmd_send), .cmd_recv(cmd_recv),
    .tx_byte(tx_byte), .sclk_in(sclk_in), .sdata_in(sdata_in),
    .sdata_out(sdata_out), .req_n(req_n), .ack_n(ack_n), .busy(busy),
    .done(done), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .timeout_err(timeout_err), .ack_warn(ack_warn)
  );

  int done_cnt = 0, rxv_cnt = 0, warn_cnt = 0, err_cnt = 0;
  always @(negedge clk) begin
    if (done)        done_cnt++;
    if (rx_valid)    rxv_cnt++;
    if (ack_warn)    warn_cnt++;
    if (timeout_err) err_cnt++;
  end

  task automatic chk(input string rq, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic start(input logic snd, input logic rcv, input logic [W-1:0] b);
    @(negedge clk);
    tx_byte = b; cmd_send = snd; cmd_recv = rcv;
    @(negedge clk);
    cmd_send = 1'b0; cmd_recv = 1'b0;
  endtask

  // peer clocks eight bits; sdata_out is sampled just before each rising edge
  task automatic xfer(input logic [W-1:0] din, output logic [W-1:0] got,
                      input int poke_at);
    for (int i = W - 1; i >= 0; i--) begin
      sclk_in = 1'b0; sdata_in = din[i];
      if (i == poke_at) begin
        tx_byte = 8'h3C; cmd_send = 1'b1; cmd_recv = 1'b1;
        @(negedge clk);
        cmd_send = 1'b0; cmd_recv = 1'b0;
        repeat (3) @(negedge clk);
      end else begin
        repeat (4) @(negedge clk);
      end
      got[i] = sdata_out;
      sclk_in = 1'b1;
      repeat (4) @(negedge clk);
    end
    sclk_in = 1'b0;
  endtask

  task automatic wait_req_high(input string rq);
    int n = 0;
    while (req_n !== 1'b1 && n < 30) begin @(negedge clk); n++; end
    chk(rq, req_n, 1);
  endtask

  task automatic finish_ack(input string rq);
    int n = 0;
    repeat (5) @(negedge clk);
    chk({rq, " no done while ack low"}, done_cnt, 0);
    chk({rq, " busy while ack low"}, busy, 1);
    ack_n = 1'b1;
    while (done_cnt == 0 && n < 20) begin @(negedge clk); n++; end
    chk({rq, " done after ack high"}, done_cnt, 1);
    chk({rq, " idle after done"}, busy, 0);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 req_n", req_n, 1);
    chk("R1 busy", busy, 0);
    chk("R1 pulses", {done, rx_valid, timeout_err, ack_warn}, 0);
    chk("R1 rx_byte", rx_byte, 0);
  endtask

  task automatic t_send(input logic [W-1:0] b);
    logic [W-1:0] got, prev;
    prev = rx_byte;
    done_cnt = 0; rxv_cnt = 0;
    start(1'b1, 1'b0, b);
    chk("R2 busy on accept", busy, 1);
    chk("R2 req_n low on accept", req_n, 0);
    ack_n = 1'b0;
    xfer(8'h00, got, -1);
    wait_req_high("R4 req released");
    finish_ack("R4 send");
    chk("R2 bits msb first", got, b);
    chk("R5 rx_byte kept", rx_byte, prev);
    chk("R5 no rx_valid", rxv_cnt, 0);
  endtask

  task automatic t_recv(input logic [W-1:0] b);
    logic [W-1:0] got;
    done_cnt = 0; rxv_cnt = 0;
    start(1'b0, 1'b1, 8'hFF);
    chk("R3 req_n low on accept", req_n, 0);
    ack_n = 1'b0;
    xfer(b, got, -1);
    wait_req_high("R4 req released rx");
    finish_ack("R4 recv");
    chk("R3 rx_byte", rx_byte, b);
    chk("R3 rx_valid pulse", rxv_cnt, 1);
  endtask

  task automatic t_timeout();
    logic [W-1:0] got;
    int n = 0;
    done_cnt = 0; err_cnt = 0;
    start(1'b1, 1'b0, 8'h5A);
    ack_n = 1'b0;
    xfer(8'h00, got, -1);
    while (req_n !== 1'b1 && n < 30) begin @(negedge clk); n++; end
    n = 0;
    while (timeout_err !== 1'b1 && n < TO + 20) begin @(negedge clk); n++; end
    chk("R6 timeout distance", n, TO);
    @(negedge clk);
    chk("R6 single error", err_cnt, 1);
    chk("R6 no done", done_cnt, 0);
    chk("R6 idle", busy, 0);
    ack_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_warn();
    logic [W-1:0] got;
    int n = 0;
    done_cnt = 0; warn_cnt = 0;
    start(1'b1, 1'b0, 8'hC3);
    xfer(8'h00, got, -1);
    while (done_cnt == 0 && n < 30) begin @(negedge clk); n++; end
    chk("R7 warn pulse", warn_cnt, 1);
    chk("R7 still done", done_cnt, 1);
    chk("R7 byte sent", got, 8'hC3);
  endtask

  task automatic t_busy_ignore();
    logic [W-1:0] got;
    done_cnt = 0;
    start(1'b1, 1'b0, 8'hA5);
    ack_n = 1'b0;
    xfer(8'h00, got, 5);
    wait_req_high("R8 req released");
    finish_ack("R8");
    chk("R8 byte unchanged", got, 8'hA5);
    repeat (6) @(negedge clk);
    chk("R8 no extra busy", busy, 0);
    chk("R8 single done", done_cnt, 1);
  endtask

  task automatic t_both();
    logic [W-1:0] got, prev;
    prev = rx_byte;
    done_cnt = 0; rxv_cnt = 0;
    start(1'b1, 1'b1, 8'h81);
    ack_n = 1'b0;
    xfer(8'h00, got, -1);
    wait_req_high("R9 req released");
    finish_ack("R9");
    chk("R9 send wins", got, 8'h81);
    chk("R9 no rx_valid", rxv_cnt, 0);
    chk("R9 rx_byte kept", rx_byte, prev);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_send(8'hB4);
    t_recv(8'h6D);
    t_send(8'h01);
    t_recv(8'h80);
    t_timeout();
    t_warn();
    t_busy_ignore();
    t_both();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule